// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This block holds two up-counters and one compare register. Every cycle it compares the register with whichever counter the select bit picks. When that counter reaches the compare value, the block performs the action held in a 4-bit mode field on a single output latch. The actions are: set the latch high, set it low, toggle it, leave it alone and only flag, or fire a special event trigger. A match in an active mode also sets a sticky compare flag.

In trigger mode the match clears the selected counter, so the compare value acts as that counter's period. The counter's own wrap flag stays clear in this case. The match also emits a one-cycle pulse that a converter can use as a start request when its enable input is high. The latch always reaches `pin_out`. The pad buffer drives the pin only while `pin_oe` is high, and the latch keeps updating while the pad floats.

Software writes the mode, select and output-enable fields together through one write strobe, and writes the compare value through another. Each counter has its own run input.

Top module: `cmp_match_unit`

## Requirements
- R1: Each counter advances by one on every clock edge while its run input is high and holds otherwise. On the edge that takes it from all-ones to zero, its wrap flag (`ovf_a_flag` or `ovf_b_flag`) is set. The flag stays set until a one is written to its clear input.
- R2: The compare value is checked against counter A when `cfg_tsel` is 0 and against counter B when it is 1. The other counter never causes a match.
- R3: A match is the first cycle in which the selected counter equals the compare value. Its action becomes visible on the outputs one clock edge later. A counter that stays at the compare value produces no further match.
- R4: With mode 1000 a match sets `pin_out` to 1. With mode 1001 a match sets it to 0.
- R5: With mode 0010 a match inverts `pin_out`.
- R6: With mode 1010 a match leaves `pin_out` unchanged and only sets the compare flag.
- R7: A match in any of the modes 1000, 1001, 0010, 1010 or 1011 sets `cmp_flag`. The flag stays set until `clr_cmp` is pulsed, and a set in the same cycle wins over the clear.
- R8: Mode 0000, and every mode value not listed in R4 to R9, is off. While the mode is off, the latch is cleared to 0 on every edge and a match does not set `cmp_flag`.
- R9: With mode 1011 a match does three things on the next edge. It clears the selected counter to zero, without setting that counter's wrap flag, even when the match value is all-ones. It leaves the other counter and `pin_out` untouched. It raises `sev_trig` for exactly one cycle. The counter period is therefore the compare value plus one.
- R10: `adc_start` pulses for one cycle together with `sev_trig` only when `adc_en` was high in the matching cycle. Otherwise it stays low.
- R11: `pin_oe` follows the output-enable bit last written through `cfg_we`. The latch on `pin_out` updates on matches whatever the value of `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_a_run | input | 1 | Counter A advances while high |
| tmr_b_run | input | 1 | Counter B advances while high |
| cfg_we | input | 1 | Writes mode, select and output-enable |
| cfg_mode | input | 4 | Match action code |
| cfg_tsel | input | 1 | Counter select, 0 = A, 1 = B |
| cfg_oe | input | 1 | Pin output-enable bit |
| cmp_we | input | 1 | Writes the compare value |
| cmp_wdata | input | TW | New compare value |
| adc_en | input | 1 | Gates the conversion start pulse |
| clr_cmp | input | 1 | Clears the compare flag (write one) |
| clr_ovf_a | input | 1 | Clears counter A wrap flag (write one) |
| clr_ovf_b | input | 1 | Clears counter B wrap flag (write one) |
| tmr_a | output | TW | Counter A value |
| tmr_b | output | TW | Counter B value |
| pin_out | output | 1 | Compare output latch |
| pin_oe | output | 1 | Pad drive enable |
| cmp_flag | output | 1 | Sticky compare match flag |
| ovf_a_flag | output | 1 | Sticky counter A wrap flag |
| ovf_b_flag | output | 1 | Sticky counter B wrap flag |
| sev_trig | output | 1 | One-cycle special event pulse |
| adc_start | output | 1 | One-cycle conversion start request |

## Verification
The bench sweeps every action mode over both counters and many compare offsets. It holds the counter on the match value for several cycles. A design that detects equality instead of arrival would keep toggling there, and the bench would catch it. The trigger tests use the all-ones compare value, which catches a design that lets the trigger clear also count as a wrap and sets the wrap flag. The bench also repeats the trigger with the conversion enable low, and it toggles output-enable between matches to show the latch still moves while the pad floats. Off and unlisted mode codes are tried after the latch was high, so a design that only ignores matches, instead of clearing the latch, is caught.

// File: rtl/cmp_match_unit.sv
module cmp_match_unit #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_a_run,
  input  logic          tmr_b_run,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_mode,
  input  logic          cfg_tsel,
  input  logic          cfg_oe,
  input  logic          cmp_we,
  input  logic [TW-1:0] cmp_wdata,
  input  logic          adc_en,
  input  logic          clr_cmp,
  input  logic          clr_ovf_a,
  input  logic          clr_ovf_b,
  output logic [TW-1:0] tmr_a,
  output logic [TW-1:0] tmr_b,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          cmp_flag,
  output logic          ovf_a_flag,
  output logic          ovf_b_flag,
  output logic          sev_trig,
  output logic          adc_start
);

  localparam logic [3:0] M_HI  = 4'b1000;
  localparam logic [3:0] M_LO  = 4'b1001;
  localparam logic [3:0] M_TGL = 4'b0010;
  localparam logic [3:0] M_IRQ = 4'b1010;
  localparam logic [3:0] M_SEV = 4'b1011;
  localparam logic [TW-1:0] TMAX = '1;

  logic [3:0]    mode_q;
  logic          tsel_q;
  logic [TW-1:0] cmp_q;
  logic          eq_q;

  logic          active, eq, hit, sev_hit, clr_a, clr_b, wrap_a, wrap_b;
  logic [TW-1:0] sel_val;

  assign active  = (mode_q == M_HI) || (mode_q == M_LO) || (mode_q == M_TGL) ||
                   (mode_q == M_IRQ) || (mode_q == M_SEV);
  assign sel_val = tsel_q ? tmr_b : tmr_a;
  assign eq      = (sel_val == cmp_q);
  assign hit     = eq && !eq_q && active;
  assign sev_hit = hit && (mode_q == M_SEV);
  assign clr_a   = sev_hit && !tsel_q;
  assign clr_b   = sev_hit && tsel_q;
  assign wrap_a  = tmr_a_run && (tmr_a == TMAX) && !clr_a;
  assign wrap_b  = tmr_b_run && (tmr_b == TMAX) && !clr_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      tsel_q <= 1'b0;
      pin_oe <= 1'b0;
      cmp_q  <= '0;
    end else begin
      if (cfg_we) begin
        mode_q <= cfg_mode;
        tsel_q <= cfg_tsel;
        pin_oe <= cfg_oe;
      end
      if (cmp_we) cmp_q <= cmp_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_a      <= '0;
      tmr_b      <= '0;
      ovf_a_flag <= 1'b0;
      ovf_b_flag <= 1'b0;
    end else begin
      if (clr_a)          tmr_a <= '0;
      else if (tmr_a_run) tmr_a <= tmr_a + 1'b1;
      if (clr_b)          tmr_b <= '0;
      else if (tmr_b_run) tmr_b <= tmr_b + 1'b1;
      ovf_a_flag <= wrap_a || (ovf_a_flag && !clr_ovf_a);
      ovf_b_flag <= wrap_b || (ovf_b_flag && !clr_ovf_b);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q      <= 1'b0;
      pin_out   <= 1'b0;
      cmp_flag  <= 1'b0;
      sev_trig  <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      eq_q      <= eq;
      cmp_flag  <= hit || (cmp_flag && !clr_cmp);
      sev_trig  <= sev_hit;
      adc_start <= sev_hit && adc_en;
      case (mode_q)
        M_HI:          if (hit) pin_out <= 1'b1;
        M_LO:          if (hit) pin_out <= 1'b0;
        M_TGL:         if (hit) pin_out <= !pin_out;
        M_IRQ, M_SEV:  pin_out <= pin_out;
        default:       pin_out <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/cmp_match_unit_chk.sv
module cmp_match_unit_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode_q,
  input logic          tsel_q,
  input logic          cfg_we,
  input logic          clr_cmp,
  input logic [TW-1:0] tmr_a,
  input logic [TW-1:0] tmr_b,
  input logic          pin_out,
  input logic          pin_oe,
  input logic          cmp_flag,
  input logic          ovf_a_flag,
  input logic          ovf_b_flag,
  input logic          sev_trig,
  input logic          adc_start
);

  logic mode_off;
  assign mode_off = !(mode_q inside {4'b1000, 4'b1001, 4'b0010, 4'b1010, 4'b1011});

  // R11
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(pin_oe));

  // R10
  adc_with_sev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> sev_trig);

  // R9
  sev_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sev_trig |=> !sev_trig);

  // R9
  sev_zero_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sev_trig && !tsel_q |-> tmr_a == '0 && !$rose(ovf_a_flag));

  // R9
  sev_zero_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sev_trig && tsel_q |-> tmr_b == '0 && !$rose(ovf_b_flag));

  // R9
  sev_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 4'b1011 |=> $stable(pin_out));

  // R6
  irq_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 4'b1010 |=> $stable(pin_out));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_flag && !clr_cmp |=> cmp_flag);

  // R8
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |=> !pin_out && !$rose(cmp_flag));

endmodule

bind cmp_match_unit cmp_match_unit_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .tsel_q(tsel_q),
  .cfg_we(cfg_we), .clr_cmp(clr_cmp), .tmr_a(tmr_a), .tmr_b(tmr_b),
  .pin_out(pin_out), .pin_oe(pin_oe), .cmp_flag(cmp_flag),
  .ovf_a_flag(ovf_a_flag), .ovf_b_flag(ovf_b_flag),
  .sev_trig(sev_trig), .adc_start(adc_start)
);

// File: tb/cmp_match_unit_bench.sv
`timescale 1ns/1ps
module cmp_match_unit_bench;
  localparam int W = 8;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_a_run = 0, tmr_b_run = 0, cfg_we = 0, cfg_tsel = 0, cfg_oe = 0;
  logic [3:0] cfg_mode = '0;
  logic cmp_we = 0;
  logic [W-1:0] cmp_wdata = '0;
  logic adc_en = 0, clr_cmp = 0, clr_ovf_a = 0, clr_ovf_b = 0;
  logic [W-1:0] tmr_a, tmr_b;
  logic pin_out, pin_oe, cmp_flag, ovf_a_flag, ovf_b_flag, sev_trig, adc_start;

  int n_chk = 0, n_fail = 0;
  int ta = 0, tb = 0;
  bit lat = 0;

  always #5 clk = ~clk;

  cmp_match_unit #(.TW(W)) u_cmp_match_unit (
    .clk(clk), .rst_n(rst_n), .tmr_a_run(tmr_a_run), .tmr_b_run(tmr_b_run),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_tsel(cfg_tsel), .cfg_oe(cfg_oe),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .adc_en(adc_en),
    .clr_cmp(clr_cmp), .clr_ovf_a(clr_ovf_a), .clr_ovf_b(clr_ovf_b),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .pin_out(pin_out), .pin_oe(pin_oe),
    .cmp_flag(cmp_flag), .ovf_a_flag(ovf_a_flag), .ovf_b_flag(ovf_b_flag),
    .sev_trig(sev_trig), .adc_start(adc_start)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      tick();
      ta = (ta + int'(tmr_a_run)) % M;
      tb = (tb + int'(tmr_b_run)) % M;
    end
  endtask

  task automatic setcfg(input logic [3:0] md, input bit sel, input bit oe);
    cfg_mode = md; cfg_tsel = sel; cfg_oe = oe; cfg_we = 1;
    tick();
    cfg_we = 0;
  endtask

  task automatic setcmp(input int v);
    cmp_wdata = W'(v); cmp_we = 1;
    tick();
    cmp_we = 0;
  endtask

  task automatic clrflag();
    clr_cmp = 1;
    tick();
    clr_cmp = 0;
  endtask

  function automatic bit is_off(input logic [3:0] md);
    return !(md inside {4'b1000, 4'b1001, 4'b0010, 4'b1010, 4'b1011});
  endfunction

  task automatic hit_test(input logic [3:0] md, input bit sel, input int off,
                          input bit oe, input string req);
    int cur, oth, c, d;
    bit act;
    cur = sel ? tb : ta;
    oth = sel ? ta : tb;
    c = (cur + off) % M;
    if (c == oth) c = (c + 1) % M;
    d = (c - cur + M) % M;
    act = !is_off(md);
    setcmp(c);
    setcfg(md, sel, oe);
    if (!act) lat = 0;
    check("R11 oe bit", pin_oe, oe);
    if (sel) tmr_b_run = 1; else tmr_a_run = 1;
    step(d);
    tmr_a_run = 0; tmr_b_run = 0;
    check("R2 selected counter at compare", sel ? tmr_b : tmr_a, c);
    check("R3 no action before edge", pin_out, lat);
    check("R3 flag not yet set", cmp_flag, 0);
    tick();
    case (md)
      4'b1000: lat = 1;
      4'b1001: lat = 0;
      4'b0010: lat = !lat;
      4'b1010: lat = lat;
      default: lat = 0;
    endcase
    check(req, pin_out, lat);
    check("R7 flag on match", cmp_flag, act);
    step(3);
    check("R3 stalled counter no rematch", pin_out, lat);
    clrflag();
    check("R7 flag cleared", cmp_flag, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] seq [9] = '{4'b1000, 4'b0010, 4'b1001, 4'b0010, 4'b1010,
                            4'b1000, 4'b1010, 4'b1001, 4'b0010};
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset tmr_a", tmr_a, 0);
    check("R1 reset tmr_b", tmr_b, 0);
    check("R8 reset pin_out", pin_out, 0);
    check("R11 reset pin_oe", pin_oe, 0);
    check("R7 reset cmp_flag", cmp_flag, 0);
    check("R1 reset ovf flags", {ovf_a_flag, ovf_b_flag}, 0);

    // R1 counting and wrap
    tmr_a_run = 1; step(10); tmr_a_run = 0;
    check("R1 tmr_a count", tmr_a, 10);
    check("R1 tmr_b held", tmr_b, 0);
    tmr_b_run = 1; step(5); tmr_b_run = 0;
    check("R1 tmr_b count", tmr_b, 5);
    tmr_a_run = 1; step(M - 11);
    check("R1 tmr_a at max", tmr_a, M - 1);
    check("R1 no early ovf", ovf_a_flag, 0);
    step(1); tmr_a_run = 0;
    check("R1 tmr_a wrapped", tmr_a, 0);
    check("R1 ovf_a set", ovf_a_flag, 1);
    step(2);
    check("R1 ovf_a sticky", ovf_a_flag, 1);
    clr_ovf_a = 1; tick(); clr_ovf_a = 0;
    check("R1 ovf_a cleared", ovf_a_flag, 0);
    tmr_b_run = 1; step(M - 5); tmr_b_run = 0;
    check("R1 tmr_b wrapped", tmr_b, 0);
    check("R1 ovf_b set", ovf_b_flag, 1);
    clr_ovf_b = 1; tick(); clr_ovf_b = 0;
    check("R1 ovf_b cleared", ovf_b_flag, 0);

    // R9 R10 trigger on counter A with all-ones compare
    setcmp(M - 1);
    setcfg(4'b1011, 0, 1);
    adc_en = 1;
    tmr_a_run = 1; step(M - 1);
    check("R9 no trigger before match", sev_trig, 0);
    step(1);
    ta = 0;
    check("R9 tmr_a cleared", tmr_a, 0);
    check("R9 sev_trig pulse", sev_trig, 1);
    check("R10 adc_start with enable", adc_start, 1);
    check("R9 no ovf on trigger clear", ovf_a_flag, 0);
    check("R7 flag on trigger", cmp_flag, 1);
    check("R9 pin unchanged", pin_out, 0);
    check("R9 tmr_b untouched", tmr_b, 0);
    adc_en = 0;
    step(1);
    check("R9 tmr_a restarts", tmr_a, 1);
    check("R9 sev_trig one cycle", sev_trig, 0);
    check("R10 adc_start one cycle", adc_start, 0);
    step(M - 2);
    check("R9 no trigger before period end", sev_trig, 0);
    step(1);
    ta = 0;
    check("R9 period second trigger", sev_trig, 1);
    check("R10 adc_start gated off", adc_start, 0);
    check("R9 no ovf second period", ovf_a_flag, 0);
    tmr_a_run = 0;
    clrflag();

    // R9 trigger on counter B
    setcmp(40);
    setcfg(4'b1011, 1, 0);
    tmr_a_run = 1; tmr_b_run = 1;
    step(40);
    step(1);
    tmr_a_run = 0; tmr_b_run = 0;
    tb = 0;
    check("R9 tmr_b cleared", tmr_b, 0);
    check("R9 tmr_a free-running", tmr_a, ta);
    check("R9 sev_trig from B", sev_trig, 1);
    clrflag();

    // R4 R5 R6 R11 sweep over both counters
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 9; i++) begin
        string rq;
        case (seq[i])
          4'b0010: rq = "R5 toggle";
          4'b1010: rq = "R6 flag only";
          default: rq = "R4 set level";
        endcase
        hit_test(seq[i], s[0], (7 + 13 * i + 31 * s) % 200 + 1, i[0], rq);
      end
    end

    // R8 off and unlisted modes
    hit_test(4'b1000, 0, 20, 1, "R4 set high");
    hit_test(4'b0000, 0, 25, 1, "R8 off clears latch");
    hit_test(4'b1000, 1, 9, 1, "R4 set high");
    hit_test(4'b0101, 1, 33, 0, "R8 unlisted mode off");
    hit_test(4'b0010, 0, 3, 0, "R5 toggle after off");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule